// File: doc/BRIEF.md
# Dual-Bank DMA Interrupt Control Register

This block collects completion events from the channels of a DMA engine and turns them into one interrupt request for the system interrupt controller. It holds two 32-bit control/status words, bank A and bank B, that share one layout. Each bank serves six channels. For every channel a bank holds an enable bit and a latched completion flag. Each bank also holds a master enable and a sticky master flag. Software reads either word through a combinational read port and writes it through a single-cycle write strobe. Flags and the master flag are cleared by writing 1 to them.

A completion pulse on an enabled channel latches that channel's flag and raises the request. In bank B, channels 2 and 3 treat their enable bits as always set. A recheck strobe scans the flags that are already latched and raises the request again when at least one of them is eligible. A recheck never creates a new flag. Any raise event in a bank that has its master enable set also sets that bank's master flag. Raise events from the two banks are merged into a single registered one-cycle pulse.

The control pins are plain level/strobe signals. No stream traffic crosses this block, so it has no valid/ready handshake and applies no back-pressure. Each event is taken in the cycle it is presented.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, both banks read 0x00000000 and `irq` is low.
- R2: Register layout for both banks: the enable of channel n is bit 16+n, the master enable is bit 23, the flag of channel n is bit 24+n, and the master flag is bit 31. A write loads bits 16..21 and 23 directly. Bits 0..15, 22 and 30 always read 0.
- R3: In bank A, a pulse on `done_a[n]` while enable 16+n is 1 sets flag 24+n at the next clock edge. `irq` is then high for the cycle that follows that edge.
- R4: In bank A, a pulse on `done_a[n]` while enable 16+n is 0 changes no flag and produces no `irq` pulse.
- R5: In bank B, a pulse on `done_b[2]` or `done_b[3]` always sets the channel's flag and raises `irq`, whatever its enable bit holds. Channels 0, 1, 4 and 5 of bank B follow the enable rule of R3/R4.
- R6: When a bank raises, whether from a completion or a recheck, and bit 23 of that bank is 1, bit 31 of that bank becomes 1 at the same edge. When bit 23 is 0, a raise leaves bit 31 unchanged.
- R7: A write with 1 in flag bit 24+n or in bit 31 clears that bit. A 0 in those positions leaves the bit unchanged.
- R8: When an eligible completion and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: A `recheck` pulse raises `irq` when, in either bank, some flag is set and that channel is eligible. A channel is eligible when its enable bit is 1, or, in bank B, when it is channel 2 or 3. A recheck sets no flag. A recheck with no eligible flag produces no pulse.
- R10: `irq` is a registered pulse, high for one cycle per cycle that contains a raise event. Raises from both banks in the same cycle give one pulse. `irq` is high only in the cycle right after a cycle that had a completion or a recheck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| done_a | input | 6 | Per-channel completion pulses, bank A |
| done_b | input | 6 | Per-channel completion pulses, bank B |
| recheck | input | 1 | Re-evaluate latched flags and re-raise |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Write target: 0 = bank A, 1 = bank B |
| wr_data | input | 32 | Write data |
| rd_bank | input | 1 | Read select: 0 = bank A, 1 = bank B |
| rd_data | output | 32 | Combinational read of the selected bank |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
A wrong internal state shows at the ports no later than the cycle after the edge that updated it. A stale enable or a wrong forced-channel mask shows up as a missing or extra `irq` pulse one cycle after the completion. A flag that is wrongly kept or wrongly cleared shows up in `rd_data` in that same cycle. A flag that is latched in error stays hidden on `irq` until the next recheck, which then pulses when it should stay quiet. For this reason, every scenario reads the affected bank back right after the event, and rechecks are issued with no eligible flags as well as with eligible ones.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int NCH       = 6;
  localparam int REG_W     = 32;
  localparam int EN_LSB    = 16;
  localparam int MEN_BIT   = 23;
  localparam int FLG_LSB   = 24;
  localparam int MFLG_BIT  = 31;
  localparam int NBANK     = 2;
endpackage

// File: rtl/dirq_bank.sv
module dirq_bank
  import dirq_pkg::*;
#(
  parameter logic [NCH-1:0] FORCED = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done,
  input  logic             recheck,
  input  logic             wr_en,
  input  logic [NCH-1:0]   wr_enb,
  input  logic             wr_men,
  input  logic [NCH-1:0]   wr_clr,
  input  logic             wr_mclr,
  output logic [REG_W-1:0] rdata,
  output logic             raise
);
  logic [NCH-1:0] en_q, flg_q;
  logic           men_q, mflg_q;
  logic [NCH-1:0] elig, set_v, clr_v;
  logic           hit;

  assign elig  = en_q | FORCED;
  assign set_v = done & elig;
  assign clr_v = wr_en ? wr_clr : '0;
  assign hit   = recheck & (|(flg_q & elig));
  assign raise = (|set_v) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flg_q  <= '0;
      men_q  <= 1'b0;
      mflg_q <= 1'b0;
    end else begin
      if (wr_en) begin
        en_q  <= wr_enb;
        men_q <= wr_men;
      end
      flg_q  <= set_v | (flg_q & ~clr_v);
      mflg_q <= (raise & men_q) | (mflg_q & ~(wr_en & wr_mclr));
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[EN_LSB +: NCH]    = en_q;
    rdata[MEN_BIT]          = men_q;
    rdata[FLG_LSB +: NCH]   = flg_q;
    rdata[MFLG_BIT]         = mflg_q;
  end

  // R6: the master flag only rises when the master enable was on
  p_mflag_needs_men_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mflg_q) |-> $past(men_q));

  // R9: a recheck alone leaves every flag untouched
  p_recheck_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck && done == '0 && !wr_en) |=> $stable(flg_q));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3: a flag never appears without a completion on its channel
    p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[i]) |-> $past(done[i]));

    // R7: write-1 clears a flag when no completion competes
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_clr[i] && !done[i]) |=> !flg_q[i]);

    if (FORCED[i]) begin : g_forced
      // R5: forced channels latch on every completion, set wins over clear (R8)
      p_forced_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done[i] |=> flg_q[i]);
    end else begin : g_gated
      // R4: gated channels need their enable to latch
      p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_q[i]) |-> $past(en_q[i]));
      // R8: an enabled completion wins over a same-cycle clear
      p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done[i] && en_q[i]) |=> flg_q[i]);
    end
  end
endmodule

// File: rtl/dirq_pulse.sv
module dirq_pulse
  import dirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] raise,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |raise;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dirq_pkg::*;
#(
  parameter logic [NCH-1:0] FORCED_B = 6'b001100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done_a,
  input  logic [NCH-1:0]   done_b,
  input  logic             recheck,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_bank,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic [NBANK-1:0][NCH-1:0]   done_v;
  logic [NBANK-1:0][REG_W-1:0] rdata_v;
  logic [NBANK-1:0]            raise_v;
  logic                        unused_wr_bits;

  assign done_v[0] = done_a;
  assign done_v[1] = done_b;
  assign unused_wr_bits = ^{wr_data[EN_LSB-1:0], wr_data[MEN_BIT-1], wr_data[MFLG_BIT-1]};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [NCH-1:0] FMASK = (b == 1) ? FORCED_B : '0;
    logic sel;
    assign sel = wr_en && (int'(wr_bank) == b);
    dirq_bank #(.FORCED(FMASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done_v[b]),
      .recheck (recheck),
      .wr_en   (sel),
      .wr_enb  (wr_data[EN_LSB +: NCH]),
      .wr_men  (wr_data[MEN_BIT]),
      .wr_clr  (wr_data[FLG_LSB +: NCH]),
      .wr_mclr (wr_data[MFLG_BIT]),
      .rdata   (rdata_v[b]),
      .raise   (raise_v[b])
    );
  end

  assign rd_data = rdata_v[rd_bank];

  dirq_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (raise_v),
    .irq   (irq)
  );

  // R10: a pulse always follows a cycle holding a completion or a recheck
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((|done_a) || (|done_b) || recheck));

  // R2: reserved bits read as zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:0] == 16'h0) && !rd_data[22] && !rd_data[30]);
endmodule

// File: tb/dma_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  done_a = '0, done_b = '0;
  logic        recheck = 1'b0, wr_en = 1'b0, wr_bank = 1'b0, rd_bank = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic        irq;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [31:0] mdl [2];

  always #4 clk = ~clk;

  dma_irq_ctrl u_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .done_a(done_a), .done_b(done_b),
    .recheck(recheck), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_data(rd_data), .irq(irq)
  );

  // Driver: presents one cycle of stimulus and queues the expected result
  task automatic step(input logic [5:0] da, input logic [5:0] db, input logic rc,
                      input logic wr, input logic wb, input logic [31:0] wd,
                      input logic rb, input string tag);
    logic [5:0] dn, elig, st, clr;
    logic rs, any;
    logic [31:0] nv;
    exp_t e;
    @(negedge clk);
    done_a = da; done_b = db; recheck = rc;
    wr_en = wr; wr_bank = wb; wr_data = wd; rd_bank = rb;
    any = 1'b0;
    for (int b = 0; b < 2; b++) begin
      logic bw;
      bw   = wr && (int'(wb) == b);
      dn   = (b == 1) ? db : da;
      elig = mdl[b][21:16] | ((b == 1) ? 6'b001100 : 6'b000000);
      st   = dn & elig;
      rs   = (|st) || (rc && (|(mdl[b][29:24] & elig)));
      clr  = bw ? wd[29:24] : 6'b0;
      nv   = '0;
      nv[29:24] = st | (mdl[b][29:24] & ~clr);
      nv[31]    = (rs && mdl[b][23]) || (mdl[b][31] && !(bw && wd[31]));
      nv[21:16] = bw ? wd[21:16] : mdl[b][21:16];
      nv[23]    = bw ? wd[23] : mdl[b][23];
      mdl[b] = nv;
      any = any | rs;
    end
    e.irq = any; e.rd = mdl[rb]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic rb, input string tag);
    step(6'b0, 6'b0, 1'b0, 1'b0, 1'b0, 32'h0, rb, tag);
  endtask

  // Monitor: pops expectations after each edge, away from the edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (irq !== e.irq) begin
          failures++;
          $display("FAIL %s irq actual=%0b expected=%0b", e.tag, irq, e.irq);
        end
        checks++;
        if (rd_data !== e.rd) begin
          failures++;
          $display("FAIL %s rd_data actual=%08h expected=%08h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mdl[0] = '0; mdl[1] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(0, "R1");
    idle(1, "R1");
    // R2: layout, reserved bits dropped
    step(0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, "R2");
    step(0, 0, 0, 1, 1, 32'h0001_0000, 1, "R2");
    // R3 and R6: enabled completions with master enable on
    step(6'b000101, 0, 0, 0, 0, 0, 0, "R3");
    idle(0, "R10");
    // R4: keep only ch1 enabled, ch0 completion ignored
    step(0, 0, 0, 1, 0, 32'h0082_0000, 0, "R2");
    step(6'b000001, 0, 0, 0, 0, 0, 0, "R4");
    step(6'b010000, 0, 0, 0, 0, 0, 0, "R4");
    // R5: forced ch2/3, gated ch1, master enable off (R6)
    step(0, 6'b001110, 0, 0, 0, 0, 1, "R5");
    step(0, 6'b000001, 0, 0, 0, 0, 1, "R5");
    step(0, 6'b100000, 0, 0, 0, 0, 1, "R5");
    // R7: write-1 clear and write-0 keep
    step(0, 0, 0, 1, 0, 32'h0182_0000, 0, "R7");
    step(0, 0, 0, 1, 0, 32'h0082_0000, 0, "R7");
    step(0, 0, 0, 1, 0, 32'h8082_0000, 0, "R7");
    // R8: completion and clear on the same flag
    step(6'b000010, 0, 0, 1, 0, 32'h0282_0000, 0, "R8");
    step(0, 0, 0, 1, 0, 32'h8082_0000, 0, "R7");
    // R9: recheck with eligible flag, re-raises master flag (R6)
    step(0, 0, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, 1, "R9");
    // R9: bank A cleared, bank B only forced flag remains
    step(0, 0, 0, 1, 0, 32'h3F82_0000, 0, "R7");
    step(0, 0, 0, 1, 1, 32'h3700_0000, 1, "R7");
    step(0, 0, 1, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 1, 32'h3F00_0000, 1, "R7");
    step(0, 0, 1, 0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, 0, 0, 0, "R9");
    // R10: both banks in one cycle give a single pulse
    step(6'b000010, 6'b000100, 0, 0, 0, 0, 1, "R10");
    idle(0, "R10");
    step(6'b000010, 0, 0, 0, 0, 0, 0, "R10");
    step(6'b000010, 0, 0, 0, 0, 0, 0, "R10");
    idle(0, "R10");
    @(negedge clk);
    done_a = '0; done_b = '0; recheck = 0; wr_en = 0;
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule